// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers 24 interrupt sources from a power-management device into three 8-bit status bytes and drives one interrupt line to the host. A rising edge on any source sets its status bit. The bit stays set until software clears the status. Two sets of three mask bytes control the flow. The latch masks decide whether a source edge is captured at all. The line masks decide whether a captured bit drives the interrupt output.

Software reaches the block through a byte-wide register port. An access with `acc_first` high takes its address from `acc_addr`. Each following access with `acc_first` low uses the previous effective address plus one. This lets a three-byte burst read return all status bytes, and lets a three-byte burst write load all masks of one kind. A write of any value to any status byte clears all 24 status bits at once.

The address map is as follows. Status bytes are at 0, 1 and 2, holding source bits 0-7, 8-15 and 16-23. Latch masks are at 4, 5 and 6. Line masks are at 8, 9 and 10. In both mask kinds, a 1 masks and a 0 enables.

Top module: `irq_agg_top`

## Requirements
- R1: A rising edge on `src_in[i]` sets status bit i when latch mask bit i is 0. Bit i reads at address i/8, bit position i%8. A set bit stays set until a clear write.
- R2: When latch mask bit i (address 4 + i/8, position i%8) is 1, an edge on `src_in[i]` does not set status bit i.
- R3: `irq_out` is 1 exactly when some status bit is set and its line mask bit (address 8 + i/8, position i%8) is 0.
- R4: A write of any data value to address 0, 1 or 2 clears all 24 status bits at the next clock edge.
- R5: When a source edge and a status clear write occur in the same cycle, that source's bit is set after the edge and all other bits are cleared.
- R6: An access with `acc_first`=1 uses `acc_addr`. Each later access with `acc_first`=0 uses the previous effective address plus one. This applies to both burst reads and burst writes.
- R7: Source bits 12 and 23 are reserved. They never become set and always read as 0.
- R8: Status bit 19 (address 2, bit 3) reads as 1 whenever status bit 20 (address 2, bit 4) is set.
- R9: After reset, all status bits are 0, all six mask bytes read 0xFF, and `irq_out` is 0. Addresses 3, 7 and 11-15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 24 | Interrupt source levels; rising edges are events |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_first | input | 1 | 1 = take address from acc_addr, 0 = continue burst |
| acc_addr | input | 4 | Start address of an access sequence |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the current effective address |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
The assertions check the following on every cycle:
- A clear write with no source activity empties the status.
- Newly set bits never appear under a set latch mask.
- No bit drops without a clear write.
- Reserved bits stay at 0.
- A fully set line mask keeps the line low.
- The mirrored bit in status byte C holds on readback.

Only the bench's scenarios can show the rest:
- Every single source is swept through latching, readback and clearing, with each clear write aimed at a different status byte.
- Burst address continuation.
- The collision where an event meets a clear write.
- Selective line unmasking.
- Unused addresses that ignore writes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [1:0] {
    RK_STAT = 2'd0,
    RK_SMSK = 2'd1,
    RK_LMSK = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] idx;
  } reg_sel_t;

  // Upper two address bits pick the register kind, lower two the byte.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned nb);
    reg_sel_t s;
    s.kind = reg_kind_e'(a[3:2]);
    s.idx  = a[1:0];
    if (32'(a[1:0]) >= nb) s.kind = RK_NONE;
    return s;
  endfunction
endpackage

// File: rtl/irq_agg_rst_sync.sv
module irq_agg_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/irq_agg_ptr.sv
module irq_agg_ptr #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_first,
  input  logic [AW-1:0] acc_addr,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    eff_addr = acc_first ? acc_addr : ptr_q;
    ptr_en   = acc_valid;
    ptr_d    = eff_addr + {{(AW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/irq_agg_mask_bank.sv
module irq_agg_mask_bank #(
  parameter int unsigned NB = 3,
  parameter int unsigned BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_idx,
  input  logic [BW-1:0]   wr_data,
  output logic [NB*BW-1:0] mask
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BW-1:0] q;
    logic          en;

    always_comb en = wr_en && (wr_idx == 2'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '1;
      else if (en) q <= wr_data;
    end

    assign mask[g*BW +: BW] = q;
  end
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int unsigned          NSRC = 24,
  parameter logic [NSRC-1:0]      RSVD = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] smask,
  input  logic            clr,
  output logic [NSRC-1:0] status
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] stat_d;

  always_comb begin
    rise   = src_in & ~src_q;
    set_v  = rise & ~smask & ~RSVD;
    // A new event outranks the clear so it is never lost.
    stat_d = (clr ? '0 : stat_q) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      stat_q <= '0;
    end else begin
      src_q  <= src_in;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 8,
  parameter logic [NUM_BANKS*BANK_W-1:0] RSVD_MASK = 24'h80_1000,
  parameter int unsigned MIR_FROM  = 20,
  parameter int unsigned MIR_TO    = 19
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_in,
  input  logic                        acc_valid,
  input  logic                        acc_write,
  input  logic                        acc_first,
  input  logic [3:0]                  acc_addr,
  input  logic [BANK_W-1:0]           acc_wdata,
  output logic [BANK_W-1:0]           acc_rdata,
  output logic                        irq_out
);
  import irq_agg_pkg::*;

  localparam int unsigned NSRC = NUM_BANKS * BANK_W;

  logic            rst_s;
  logic [3:0]      eff_addr;
  reg_sel_t        sel;
  logic            wr_go;
  logic            clr;
  logic            smask_we;
  logic            lmask_we;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] smask;
  logic [NSRC-1:0] lmask;
  logic [NSRC-1:0] stat_view;

  irq_agg_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  irq_agg_ptr #(.AW(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_s),
    .acc_valid (acc_valid),
    .acc_first (acc_first),
    .acc_addr  (acc_addr),
    .eff_addr  (eff_addr)
  );

  always_comb begin
    sel      = decode_addr(eff_addr, NUM_BANKS);
    wr_go    = acc_valid && acc_write;
    clr      = wr_go && (sel.kind == RK_STAT);
    smask_we = wr_go && (sel.kind == RK_SMSK);
    lmask_we = wr_go && (sel.kind == RK_LMSK);
  end

  irq_agg_status #(.NSRC(NSRC), .RSVD(RSVD_MASK)) u_stat (
    .clk    (clk),
    .rst_n  (rst_s),
    .src_in (src_in),
    .smask  (smask),
    .clr    (clr),
    .status (status)
  );

  irq_agg_mask_bank #(.NB(NUM_BANKS), .BW(BANK_W)) u_smask (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (smask_we),
    .wr_idx  (sel.idx),
    .wr_data (acc_wdata),
    .mask    (smask)
  );

  irq_agg_mask_bank #(.NB(NUM_BANKS), .BW(BANK_W)) u_lmask (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (lmask_we),
    .wr_idx  (sel.idx),
    .wr_data (acc_wdata),
    .mask    (lmask)
  );

  // Readback view: the lower mirror bit also shows the upper one.
  always_comb begin
    stat_view         = status;
    stat_view[MIR_TO] = status[MIR_TO] | status[MIR_FROM];
  end

  always_comb begin
    acc_rdata = '0;
    case (sel.kind)
      RK_STAT: acc_rdata = stat_view[32'(sel.idx)*BANK_W +: BANK_W];
      RK_SMSK: acc_rdata = smask[32'(sel.idx)*BANK_W +: BANK_W];
      RK_LMSK: acc_rdata = lmask[32'(sel.idx)*BANK_W +: BANK_W];
      default: acc_rdata = '0;
    endcase
  end

  assign irq_out = |(status & ~lmask);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 8,
  parameter logic [NUM_BANKS*BANK_W-1:0] RSVD_MASK = 24'h80_1000,
  parameter int unsigned MIR_FROM  = 20,
  parameter int unsigned MIR_TO    = 19
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_BANKS*BANK_W-1:0] src_in,
  input logic [NUM_BANKS*BANK_W-1:0] status,
  input logic [NUM_BANKS*BANK_W-1:0] smask,
  input logic [NUM_BANKS*BANK_W-1:0] lmask,
  input logic                        irq_out,
  input logic                        acc_valid,
  input logic                        acc_write,
  input logic [3:0]                  eff_addr,
  input logic [BANK_W-1:0]           acc_rdata
);
  import irq_agg_pkg::*;

  localparam int unsigned MIR_BANK = MIR_FROM / BANK_W;
  localparam int unsigned MIR_HI   = MIR_FROM % BANK_W;
  localparam int unsigned MIR_LO   = MIR_TO % BANK_W;

  reg_sel_t sel;
  logic     wr_stat;
  logic     rd_mir;

  always_comb begin
    sel     = decode_addr(eff_addr, NUM_BANKS);
    wr_stat = acc_valid && acc_write && (sel.kind == RK_STAT);
    rd_mir  = acc_valid && !acc_write && (eff_addr == 4'(MIR_BANK));
  end

  // R1: a set bit only drops on a clear write
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> (($past(status) & ~status) == '0));

  // R2: newly set bits never appear under a set latch mask
  p_latch_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & $past(smask)) == '0));

  // R3: a fully set line mask keeps the line low
  p_line_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&lmask) |-> !irq_out);

  // R4: a clear write with quiet sources empties the status
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (src_in == '0)) |=> (status == '0));

  // R7: reserved bits stay zero
  p_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status & RSVD_MASK) == '0);

  // R8: mirrored readback in the top status byte
  p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mir && acc_rdata[MIR_HI]) |-> acc_rdata[MIR_LO]);
endmodule

bind irq_agg_top irq_agg_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .RSVD_MASK (RSVD_MASK),
  .MIR_FROM  (MIR_FROM),
  .MIR_TO    (MIR_TO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .src_in    (src_in),
  .status    (status),
  .smask     (smask),
  .lmask     (lmask),
  .irq_out   (irq_out),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .eff_addr  (eff_addr),
  .acc_rdata (acc_rdata)
);

// File: tb/sim_irq_agg_top.sv
`timescale 1ns/1ps
module sim_irq_agg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] src_in;
  logic        acc_valid, acc_write, acc_first;
  logic [3:0]  acc_addr;
  logic [7:0]  acc_wdata;
  logic [7:0]  acc_rdata;
  logic        irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [23:0] exp_st;
  logic [7:0]  rb [0:2];

  always #2.5 clk = ~clk;

  irq_agg_top u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_first(acc_first),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .irq_out(irq_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("FAIL watchdog: act=%0d cycles exp=done", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [23:0] st, input int k);
    logic [23:0] v;
    v = st;
    if (v[20]) v[19] = 1'b1;
    return v[k*8 +: 8];
  endfunction

  task automatic bus_idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_first = 1'b0;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d, input logic first);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_first = first;
    acc_addr = a; acc_wdata = d;
    @(posedge clk);
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic first, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_first = first; acc_addr = a;
    #1 d = acc_rdata;
    @(posedge clk);
  endtask

  task automatic rd_burst3(input logic [3:0] a);
    bus_rd(a, 1'b1, rb[0]);
    bus_rd(4'hF, 1'b0, rb[1]);
    bus_rd(4'hF, 1'b0, rb[2]);
  endtask

  task automatic pulse(input logic [23:0] v);
    @(negedge clk);
    acc_valid = 1'b0; src_in = v;
    @(negedge clk);
    src_in = '0;
    #1;
  endtask

  task automatic wr_burst3(input logic [3:0] a, input logic [23:0] v);
    bus_wr(a, v[7:0], 1'b1);
    bus_wr(4'hF, v[15:8], 1'b0);
    bus_wr(4'hF, v[23:16], 1'b0);
    bus_idle();
  endtask

  task automatic check_status(input string req);
    rd_burst3(4'd0);
    for (int k = 0; k < 3; k++) chk(req, {24'h0, rb[k]}, {24'h0, exp_byte(exp_st, k)});
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; src_in = '0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_first = 1'b0; acc_addr = '0; acc_wdata = '0;
    exp_st = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R9 reset state
    #1 chk("R9 irq", {31'h0, irq_out}, 0);
    check_status("R9 status");
    rd_burst3(4'd4);
    for (int k = 0; k < 3; k++) chk("R9 smask", {24'h0, rb[k]}, 32'hFF);
    rd_burst3(4'd8);
    for (int k = 0; k < 3; k++) chk("R9 lmask", {24'h0, rb[k]}, 32'hFF);

    // R2 masked by default: no latching
    pulse(24'hFFFFFF);
    bus_idle();
    check_status("R2 masked");
    chk("R2 irq", {31'h0, irq_out}, 0);

    // R6 burst writes to both mask kinds
    wr_burst3(4'd4, 24'h000000);
    wr_burst3(4'd8, 24'h000000);
    rd_burst3(4'd4);
    for (int k = 0; k < 3; k++) chk("R6 smask burst", {24'h0, rb[k]}, 0);
    rd_burst3(4'd8);
    for (int k = 0; k < 3; k++) chk("R6 lmask burst", {24'h0, rb[k]}, 0);

    // R1/R3/R4/R7/R8 sweep every source; clear through each status byte
    for (int i = 0; i < 24; i++) begin
      pulse(24'(1) << i);
      if (i != 12 && i != 23) exp_st[i] = 1'b1;
      chk((i == 12 || i == 23) ? "R7 reserved irq" : "R3 irq", {31'h0, irq_out}, {31'h0, exp_st != 0});
      check_status((i == 12 || i == 23) ? "R7 reserved" : (i == 20 ? "R8 mirror" : "R1 latch"));
      bus_wr(4'(i % 3), 8'(i * 37), 1'b1);
      bus_idle();
      exp_st = '0;
      #1 chk("R4 clear irq", {31'h0, irq_out}, 0);
      check_status("R4 clear");
    end

    // R1 sticky: several bits accumulate, stay across idle cycles
    pulse(24'h000041);
    pulse(24'h420000);
    exp_st = 24'h420041;
    repeat (5) bus_idle();
    check_status("R1 sticky");
    bus_wr(4'd1, 8'hA5, 1'b1);
    bus_idle();
    exp_st = '0;

    // R3 line masks gate the output selectively
    wr_burst3(4'd8, 24'hFFFFFF);
    pulse(24'h000020);
    exp_st = 24'h000020;
    chk("R3 lmasked", {31'h0, irq_out}, 0);
    check_status("R3 status held");
    bus_wr(4'd8, 8'hDF, 1'b1);
    bus_idle();
    #1 chk("R3 unmasked", {31'h0, irq_out}, 1);
    bus_wr(4'd8, 8'hFE, 1'b1);
    bus_idle();
    #1 chk("R3 other bit", {31'h0, irq_out}, 0);
    wr_burst3(4'd8, 24'h000000);
    #1 chk("R3 all open", {31'h0, irq_out}, 1);

    // R5 event in the clear cycle survives, older bit cleared
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_first = 1'b1; acc_addr = 4'd2;
    acc_wdata = 8'h00; src_in = 24'h000200;
    @(negedge clk);
    acc_valid = 1'b0; src_in = '0;
    exp_st = 24'h000200;
    check_status("R5 collision");

    // R8 mirror with bit 20 only, and bit 19 alone
    bus_wr(4'd0, 8'h00, 1'b1); bus_idle();
    pulse(24'h100000);
    bus_rd(4'd2, 1'b1, d);
    chk("R8 mirror 20", {24'h0, d}, 32'h18);
    bus_wr(4'd0, 8'h00, 1'b1); bus_idle();
    pulse(24'h080000);
    bus_rd(4'd2, 1'b1, d);
    chk("R8 bit19 alone", {24'h0, d}, 32'h08);
    bus_wr(4'd0, 8'h00, 1'b1); bus_idle();

    // R2 single latch-mask bit blocks only its source
    bus_wr(4'd5, 8'h02, 1'b1); bus_idle();
    pulse(24'h000300);
    exp_st = 24'h000100;
    check_status("R2 partial mask");
    bus_wr(4'd0, 8'h00, 1'b1); bus_idle();
    exp_st = '0;

    // R9 unused addresses: reads zero, writes ignored
    for (int a = 0; a < 16; a++) begin
      if (a == 3 || a == 7 || a >= 11) begin
        bus_wr(4'(a), 8'h00, 1'b1);
        bus_rd(4'(a), 1'b1, d);
        chk("R9 unused read", {24'h0, d}, 0);
      end
    end
    bus_idle();
    rd_burst3(4'd4);
    chk("R9 smask kept", {24'h0, rb[0], rb[1], rb[2]}, 32'h000200);
    rd_burst3(4'd8);
    chk("R9 lmask kept", {24'h0, rb[0], rb[1], rb[2]}, 32'h000000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule